// File: doc/BRIEF.md
# Chip-Select Inactivity Release

This block owns the active-low chip-select of a serial flash controller in memory-mapped mode. When a read access ends, chip-select is not dropped at once. It stays low so that a later access to the next address can continue the same burst without a new command phase. While chip-select is held with no access in progress, a counter counts clock cycles. When the count reaches a programmable 16-bit limit, chip-select is released and a sticky timeout flag is set. The flag can raise an interrupt through a separate enable.

In any other functional mode, chip-select drops as soon as the access ends and the counter stays idle. If the counter is disabled, chip-select is held for as long as the controller stays enabled. An abort request, or clearing the controller enable, releases chip-select on the next edge and clears the counter. The serial engine supplies one-cycle pulses that mark the start and the end of each access.

Top module: `cs_idle_release`

## Requirements
- R1: After synchronous reset, cs_n is 1, tmo_flag is 0 and tmo_irq is 0.
- R2: An acc_start pulse sampled while ctl_en=1 and abort_req=0 drives cs_n to 0 from the next edge, and cs_n stays 0 while the access is in progress.
- R3: In memory-mapped mode (mm_mode=1) with tmo_en=0, cs_n stays 0 indefinitely after acc_end.
- R4: In memory-mapped mode with tmo_en=1, cs_n rises at the L-th edge after the edge that samples acc_end, where L is tmo_limit (16 bits). A limit of 0 acts as 1.
- R5: An acc_start sampled while chip-select is held keeps cs_n at 0. The idle count for the next hold period starts again from zero.
- R6: With mm_mode=0, acc_end releases cs_n at the next edge. Clearing mm_mode during a hold also releases cs_n at the next edge. Neither case sets tmo_flag.
- R7: tmo_flag goes to 1 on the same edge at which a timeout releases cs_n. It stays 1 until a tmo_flag_clr pulse. A timeout on the same edge as a clear leaves the flag at 1.
- R8: tmo_irq equals the flag value after each edge ANDed with tmo_irq_en sampled at that edge.
- R9: abort_req=1 or ctl_en=0 sets cs_n to 1 at the next edge and resets the counter. This takes priority over acc_start and leaves tmo_flag unchanged.
- R10: acc_end while no access is in progress has no effect. acc_start while ctl_en=0 has no effect.
- R11: Clearing tmo_en during a hold resets the idle count to zero. After tmo_en is set again, the full limit must elapse before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable |
| abort_req | input | 1 | Abort request, releases chip-select |
| tmo_en | input | 1 | Inactivity counter enable |
| tmo_limit | input | 16 | Idle cycles before release |
| mm_mode | input | 1 | 1 when the controller is in memory-mapped mode |
| acc_start | input | 1 | One-cycle pulse: an access begins |
| acc_end | input | 1 | One-cycle pulse: the current access ends |
| tmo_irq_en | input | 1 | Timeout interrupt enable |
| tmo_flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| cs_n | output | 1 | Chip-select, active low, registered |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Timeout interrupt |

## Verification
The assertions assume that every input carries a known value at each sampled edge after reset. They also assume that abort and disable always override a start, so that a start pulse is checked only when no kill condition is present in the same cycle.

The properties do not depend on tmo_limit staying constant during a hold. Expiry is a greater-or-equal comparison, so lowering the limit in the middle of a hold is still legal.

The random stimulus changes tmo_limit only while the reference model shows chip-select released. This keeps each directed count of the release cycle well defined. Mode, enable and abort still change at arbitrary cycles, so the bench also exercises the override paths.

// File: rtl/csto_pkg.sv
`timescale 1ns/1ps
package csto_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } cs_state_e;
endpackage

// File: rtl/csto_idle_counter.sv
`timescale 1ns/1ps
module csto_idle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + EXT_W'(1);
  assign hit     = run && (cnt_nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (run)
      cnt_q <= cnt_nxt[CNT_W-1:0];
  end

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R4
  idle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && !hit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/csto_fsm.sv
`timescale 1ns/1ps
module csto_fsm
  import csto_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      kill,
  input  logic      start,
  input  logic      fin,
  input  logic      mm,
  input  logic      hit,
  output cs_state_e state_q,
  output logic      cs_n_q,
  output logic      expire
);
  cs_state_e state_d;

  always_comb begin
    state_d = state_q;
    expire  = 1'b0;
    if (kill) begin
      state_d = ST_IDLE;
    end else if (start) begin
      state_d = ST_BUSY;
    end else begin
      unique case (state_q)
        ST_BUSY: if (fin) state_d = mm ? ST_HOLD : ST_IDLE;
        ST_HOLD: begin
          if (!mm) begin
            state_d = ST_IDLE;
          end else if (hit) begin
            state_d = ST_IDLE;
            expire  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cs_n_q  <= (state_d == ST_IDLE);
    end
  end

  // R6
  leave_mm_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && !mm && !kill && !start) |=> (cs_n_q && !$past(expire)));

  // R10
  idle_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=> cs_n_q);
endmodule

// File: rtl/csto_flag.sv
`timescale 1ns/1ps
module csto_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_q
);
  logic flag_d;

  assign flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en;
    end
  end

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);

  // R7
  flag_setwin_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> flag_q);
endmodule

// File: rtl/cs_idle_release.sv
`timescale 1ns/1ps
module cs_idle_release
  import csto_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_en,
  input  logic               abort_req,
  input  logic               tmo_en,
  input  logic [LIMIT_W-1:0] tmo_limit,
  input  logic               mm_mode,
  input  logic               acc_start,
  input  logic               acc_end,
  input  logic               tmo_irq_en,
  input  logic               tmo_flag_clr,
  output logic               cs_n,
  output logic               tmo_flag,
  output logic               tmo_irq
);
  cs_state_e st;
  logic kill, hold_run, cnt_clr, cnt_hit, expire, cs_n_q;

  assign kill     = abort_req | ~ctl_en;
  assign hold_run = (st == ST_HOLD) && mm_mode && tmo_en && !kill && !acc_start;
  assign cnt_clr  = !hold_run;

  csto_idle_counter #(.CNT_W(LIMIT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .run   (hold_run),
    .limit (tmo_limit),
    .hit   (cnt_hit)
  );

  csto_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .kill    (kill),
    .start   (acc_start),
    .fin     (acc_end),
    .mm      (mm_mode),
    .hit     (cnt_hit),
    .state_q (st),
    .cs_n_q  (cs_n_q),
    .expire  (expire)
  );

  csto_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (expire),
    .clr    (tmo_flag_clr),
    .irq_en (tmo_irq_en),
    .flag_q (tmo_flag),
    .irq_q  (tmo_irq)
  );

  assign cs_n = cs_n_q;

  // R9
  kill_release_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> cs_n);

  // R2
  start_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_start && !kill) |=> !cs_n);

  // R7
  flag_with_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_flag) |-> $rose(cs_n));

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_irq |-> tmo_flag);

  // R3
  no_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !tmo_en && !kill && mm_mode) |=> !cs_n);
endmodule

// File: tb/cs_idle_release_tb.sv
`timescale 1ns/1ps
module cs_idle_release_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_en = 1'b0, abort_req = 1'b0, tmo_en = 1'b0, mm_mode = 1'b0;
  logic [15:0] tmo_limit = 16'd0;
  logic        acc_start = 1'b0, acc_end = 1'b0, tmo_irq_en = 1'b0, tmo_flag_clr = 1'b0;
  logic        cs_n, tmo_flag, tmo_irq;

  int total = 0;
  int fails = 0;

  // reference model: 0 released, 1 access, 2 holding
  int m_st = 0;
  int m_cnt = 0;
  bit m_flag = 0, m_irq = 0;

  always #5 clk = ~clk;

  cs_idle_release u_dut (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .abort_req(abort_req),
    .tmo_en(tmo_en), .tmo_limit(tmo_limit), .mm_mode(mm_mode),
    .acc_start(acc_start), .acc_end(acc_end), .tmo_irq_en(tmo_irq_en),
    .tmo_flag_clr(tmo_flag_clr), .cs_n(cs_n), .tmo_flag(tmo_flag), .tmo_irq(tmo_irq)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit tmo = 0;
    if (abort_req || !ctl_en) begin
      m_st = 0; m_cnt = 0;
    end else if (acc_start) begin
      m_st = 1; m_cnt = 0;
    end else if (m_st == 1) begin
      if (acc_end) begin m_st = mm_mode ? 2 : 0; m_cnt = 0; end
    end else if (m_st == 2) begin
      if (!mm_mode) begin
        m_st = 0; m_cnt = 0;
      end else if (!tmo_en) begin
        m_cnt = 0;
      end else if (m_cnt + 1 >= int'(tmo_limit)) begin
        m_st = 0; m_cnt = 0; tmo = 1;
      end else begin
        m_cnt++;
      end
    end
    m_flag = tmo | (m_flag & !tmo_flag_clr);
    m_irq  = m_flag & tmo_irq_en;
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    chk("R4 cs_n", int'(cs_n), (m_st == 0) ? 1 : 0);
    chk("R7 flag", int'(tmo_flag), int'(m_flag));
    chk("R8 irq", int'(tmo_irq), int'(m_irq));
  endtask

  task automatic pulse_start();
    acc_start = 1'b1; step(); acc_start = 1'b0;
  endtask

  task automatic pulse_end();
    acc_end = 1'b1; step(); acc_end = 1'b0;
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (cs_n == 1'b0 && n < 100000) begin
      step();
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    bit fsave;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 flag", int'(tmo_flag), 0);
    chk("R1 irq", int'(tmo_irq), 0);

    ctl_en = 1; mm_mode = 1; tmo_en = 1; tmo_limit = 16'd5;
    pulse_start();
    chk("R2 cs_n low after start", int'(cs_n), 0);
    repeat (3) step();
    chk("R2 cs_n low during access", int'(cs_n), 0);
    pulse_end();
    count_release(n);
    chk("R4 release after limit", n, 4 + 1);
    chk("R7 flag set on expiry", int'(tmo_flag), 1);
    chk("R8 irq off when disabled", int'(tmo_irq), 0);
    repeat (4) step();
    chk("R7 flag sticky", int'(tmo_flag), 1);
    tmo_flag_clr = 1; step(); tmo_flag_clr = 0;
    chk("R7 flag cleared", int'(tmo_flag), 0);

    tmo_irq_en = 1;
    pulse_start(); pulse_end();
    count_release(n);
    chk("R8 irq raised", int'(tmo_irq), 1);
    tmo_flag_clr = 1; step(); tmo_flag_clr = 0;
    chk("R8 irq follows cleared flag", int'(tmo_irq), 0);

    // R3 counter disabled
    tmo_en = 0;
    pulse_start(); pulse_end();
    repeat (50) step();
    chk("R3 cs_n held indefinitely", int'(cs_n), 0);
    // R11 re-enable counts full limit
    tmo_en = 1; repeat (3) step();
    tmo_en = 0; step();
    tmo_en = 1;
    count_release(n);
    chk("R11 full limit after re-enable", n, 5);

    // R5 restart during hold
    tmo_limit = 16'd4;
    pulse_start(); pulse_end();
    repeat (2) step();
    pulse_start();
    chk("R5 cs_n kept low", int'(cs_n), 0);
    pulse_end();
    count_release(n);
    chk("R5 count restarts", n, 4);
    tmo_flag_clr = 1; step(); tmo_flag_clr = 0;

    // R6 non memory-mapped
    mm_mode = 0;
    pulse_start(); pulse_end();
    chk("R6 release at access end", int'(cs_n), 1);
    chk("R6 no flag", int'(tmo_flag), 0);
    mm_mode = 1;
    pulse_start(); pulse_end(); step();
    mm_mode = 0; step(); mm_mode = 1;
    chk("R6 mode exit releases", int'(cs_n), 1);
    chk("R6 mode exit no flag", int'(tmo_flag), 0);

    // R9 abort wins over start, flag untouched
    pulse_start(); pulse_end(); count_release(n);
    fsave = tmo_flag;
    pulse_start();
    abort_req = 1; acc_start = 1; step(); abort_req = 0; acc_start = 0;
    chk("R9 abort releases", int'(cs_n), 1);
    chk("R9 flag unchanged", int'(tmo_flag), int'(fsave));
    pulse_start(); pulse_end();
    ctl_en = 0; step();
    chk("R9 disable releases", int'(cs_n), 1);
    pulse_start();
    chk("R10 start ignored when disabled", int'(cs_n), 1);
    ctl_en = 1;
    pulse_end();
    chk("R10 end ignored when idle", int'(cs_n), 1);

    // R4 limit 0 and large limit
    tmo_limit = 16'd0;
    pulse_start(); pulse_end(); count_release(n);
    chk("R4 zero limit acts as one", n, 1);
    tmo_limit = 16'd300;
    pulse_start(); pulse_end(); count_release(n);
    chk("R4 large limit", n, 300);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      ctl_en       = ($urandom_range(99) < 98);
      abort_req    = ($urandom_range(99) < 2);
      acc_start    = ($urandom_range(99) < 8);
      acc_end      = ($urandom_range(99) < 20);
      tmo_flag_clr = ($urandom_range(99) < 4);
      if ($urandom_range(99) < 3) mm_mode = ~mm_mode;
      if ($urandom_range(99) < 3) tmo_en = ~tmo_en;
      if ($urandom_range(99) < 5) tmo_irq_en = ~tmo_irq_en;
      if (m_st == 0 && $urandom_range(99) < 10) tmo_limit = 16'($urandom_range(12));
      step();
    end
    acc_start = 0; acc_end = 0; abort_req = 0; tmo_flag_clr = 0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule